// File: doc/BRIEF.md
# Parallel Port FIFO Service and Fault Interrupt Controller

This block holds the extended control register and the service logic for an enhanced parallel port. One 16-byte FIFO is shared by every transfer. A direction input decides who writes and who reads it. When direction is 0 the host pushes and the peripheral side pops. When direction is 1 the peripheral side pushes and the host reads. Software sees the FIFO full and empty flags, a DMA enable, a self-disabling service latch, an error-interrupt disable and a free 3-bit mode field, all in one 8-bit control register.

The service latch re-arms only when software writes it to 0. While it is armed, hardware sets it on the first service event. The event is chosen by mode. With DMA on, it is the DMA terminal count. With DMA off, it is enough free room (direction 0) or enough stored bytes (direction 1), with the thresholds set by parameters. The setting edge also raises a one-cycle interrupt pulse. A separate error path pulses the same interrupt on a falling edge of the synchronized fault line. It also pulses when software enables error interrupts while the line is already low.

Top module: `ecp_svc_ctrl`

## Requirements
- R1: Control bit 0 reads 1 exactly when the FIFO holds no byte. Bits 0 and 1 are never 1 together.
- R2: Control bit 1 reads 1 exactly when all 16 locations are used. A push into a full FIFO is dropped and leaves the stored bytes unchanged.
- R3: Bytes leave the FIFO in the order they entered. Direction 0 routes host writes to the peripheral pop port. Direction 1 routes peripheral pushes to the host read port.
- R4: After reset the control register reads 0x15: mode 0, error interrupt disabled, DMA off, service latch set, FIFO empty. The interrupt and the DMA request enable are 0.
- R5: Control bit 3 is the DMA enable and is written directly. The DMA request enable output is 1 only while bit 3 is 1 and bit 2 is 0.
- R6: With DMA off and direction 0, an armed latch (bit 2 = 0) is set once free space reaches WR_TH (default 8). The interrupt pulses for one cycle in the cycle after the condition first holds. With 7 free bytes there is no event.
- R7: With DMA off and direction 1, an armed latch is set once the stored count reaches RD_TH (default 8). With 7 stored bytes there is no event.
- R8: With DMA on, only a terminal-count pulse sets the armed latch and fires the interrupt, in the cycle after the pulse. The FIFO thresholds have no effect.
- R9: While bit 2 is 1, no service interrupt occurs and only a software write clears the bit. Writing 1 to bit 2 never causes an interrupt.
- R10: With bit 4 = 0, a high-to-low transition of the fault input gives a one-cycle interrupt 3 clock edges later. With bit 4 = 1, or on a rising transition, no interrupt occurs.
- R11: A write that changes bit 4 from 1 to 0 while the synchronized fault line is low pulses the interrupt in the cycle after the write. Writing 0 when bit 4 is already 0 does not.
- R12: Bits 7:5 read back what was written and affect neither the interrupt nor the DMA request enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir | input | 1 | Transfer direction: 0 host to peripheral, 1 peripheral to host |
| host_wr_en | input | 1 | Host push strobe (used when dir = 0) |
| host_wr_data | input | 8 | Host push byte |
| host_rd_en | input | 1 | Host pop strobe (used when dir = 1) |
| host_rd_data | output | 8 | Oldest stored byte, host view |
| per_push | input | 1 | Peripheral push strobe (used when dir = 1) |
| per_push_data | input | 8 | Peripheral push byte |
| per_pop | input | 1 | Peripheral pop strobe (used when dir = 0) |
| per_pop_data | output | 8 | Oldest stored byte, peripheral view |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write value |
| reg_rdata | output | 8 | Control register read value |
| dma_tc | input | 1 | DMA terminal count pulse |
| nfault | input | 1 | Asynchronous active-low fault line |
| irq | output | 1 | One-cycle interrupt pulse |
| dma_req_en | output | 1 | DMA request enable |

## Verification
Register writes, FIFO occupancy and the flags change on the edge that takes the strobe. The control read-back and the head byte can therefore be sampled at the falling edge after that one rising edge. A service event needs one more edge: the latch and the interrupt register update on the edge after the condition first holds. Each check waits exactly that long and also confirms the interrupt was still 0 one cycle earlier. A fault edge passes two synchronizer flops and the interrupt register, so the bench samples the pulse 3 edges after driving the input and verifies 0 on the edges around it. Every sample is taken at the falling clock edge.

// File: rtl/ecp_svc_pkg.sv
// Package: control register layout shared by the controller and its checker.
// Assumes an 8-bit control register; bit positions are fixed because software decodes them.
package ecp_svc_pkg;
    localparam int BIT_EMPTY   = 0;
    localparam int BIT_FULL    = 1;
    localparam int BIT_SVC     = 2;
    localparam int BIT_DMA     = 3;
    localparam int BIT_ERR_DIS = 4;
    localparam int MODE_LSB    = 5;

    // Writable part of the control register.
    typedef struct packed {
        logic [2:0] mode;
        logic       err_dis;
        logic       dma_en;
        logic       svc;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{mode: 3'd0, err_dis: 1'b1, dma_en: 1'b0, svc: 1'b1};

    // Builds the read value from the stored fields and the live FIFO flags.
    function automatic logic [7:0] ctl_read(input ctl_t c, input logic full, input logic empty);
        return {c.mode, c.err_dis, c.dma_en, c.svc, full, empty};
    endfunction
endpackage

// File: rtl/ecp_byte_fifo.sv
// Module: ecp_byte_fifo
// Single-clock FIFO with show-ahead head output and an occupancy count.
// Assumes: pushes into a full FIFO and pops from an empty one are dropped;
// a push and a pop in the same cycle are both honoured when legal.
module ecp_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == FULL_C);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/ecp_fault_irq.sv
// Module: ecp_fault_irq
// Synchronizes the active-low fault line and raises a one-cycle event on its
// falling edge while enabled, or when software enables it while the line is low.
// Assumes the line idles high; the synchronizer resets to the idle level.
module ecp_fault_irq #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nfault_in,
    input  logic err_dis,
    input  logic enable_wr,
    output logic line_low,
    output logic evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   fall;

    // Synchronizer chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], nfault_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign line_low = !sync_q[SYNC_STAGES-1];
    assign fall     = prev_q && line_low;

    // Event: edge while enabled, or enable being cleared over a low line.
    always_comb begin
        evt = (!err_dis && fall) || (err_dis && enable_wr && line_low);
    end
endmodule

// File: rtl/ecp_svc_event.sv
// Module: ecp_svc_event
// Selects the service condition from DMA enable and direction.
// Assumes the count is the FIFO occupancy, from 0 to DEPTH.
module ecp_svc_event #(
    parameter int DEPTH = 16,
    parameter int WR_TH = 8,
    parameter int RD_TH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          dma_en,
    input  logic          dir,
    input  logic          dma_tc,
    input  logic [CW-1:0] count,
    output logic          cond
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] WR_TH_C = CW'(WR_TH);
    localparam logic [CW-1:0] RD_TH_C = CW'(RD_TH);

    logic [CW-1:0] free_cnt;
    assign free_cnt = DEPTH_C - count;

    // Mode-dependent condition.
    always_comb begin
        if (dma_en)   cond = dma_tc;
        else if (dir) cond = (count >= RD_TH_C);
        else          cond = (free_cnt >= WR_TH_C);
    end
endmodule

// File: rtl/ecp_svc_ctrl.sv
// Module: ecp_svc_ctrl (top)
// Control register, shared FIFO routing, self-disabling service latch and
// merged interrupt pulse for an enhanced parallel port.
// Assumes a single clock domain except for nfault, which is synchronized here.
module ecp_svc_ctrl
    import ecp_svc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WR_TH = 8,
    parameter int RD_TH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dir,
    input  logic       host_wr_en,
    input  logic [7:0] host_wr_data,
    input  logic       host_rd_en,
    output logic [7:0] host_rd_data,
    input  logic       per_push,
    input  logic [7:0] per_push_data,
    input  logic       per_pop,
    output logic [7:0] per_pop_data,
    input  logic       reg_wr_en,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       dma_tc,
    input  logic       nfault,
    output logic       irq,
    output logic       dma_req_en
);
    ctl_t          ctl_q;
    logic          f_push, f_pop, f_full, f_empty;
    logic [7:0]    f_wdata, f_head;
    logic [CW-1:0] f_count;
    logic          svc_cond, svc_evt, flt_evt, flt_low, irq_q;

    // Direction routes one writer and one reader onto the shared FIFO.
    always_comb begin
        f_push  = dir ? per_push      : host_wr_en;
        f_wdata = dir ? per_push_data : host_wr_data;
        f_pop   = dir ? host_rd_en    : per_pop;
    end

    ecp_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(f_push), .push_data(f_wdata), .pop(f_pop),
        .head(f_head), .count(f_count), .full(f_full), .empty(f_empty)
    );

    ecp_svc_event #(.DEPTH(DEPTH), .WR_TH(WR_TH), .RD_TH(RD_TH)) u_evt (
        .dma_en(ctl_q.dma_en), .dir(dir), .dma_tc(dma_tc),
        .count(f_count), .cond(svc_cond)
    );

    ecp_fault_irq #(.SYNC_STAGES(2)) u_flt (
        .clk(clk), .rst_n(rst_n), .nfault_in(nfault),
        .err_dis(ctl_q.err_dis),
        .enable_wr(reg_wr_en && !reg_wdata[BIT_ERR_DIS]),
        .line_low(flt_low), .evt(flt_evt)
    );

    assign svc_evt = !ctl_q.svc && svc_cond;

    // Control register: software writes win; otherwise hardware may set the latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else if (reg_wr_en) begin
            ctl_q.mode    <= reg_wdata[7:MODE_LSB];
            ctl_q.err_dis <= reg_wdata[BIT_ERR_DIS];
            ctl_q.dma_en  <= reg_wdata[BIT_DMA];
            ctl_q.svc     <= reg_wdata[BIT_SVC];
        end else if (svc_evt) begin
            ctl_q.svc <= 1'b1;
        end
    end

    // One-cycle interrupt pulse from either source.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= svc_evt || flt_evt;
    end

    assign irq          = irq_q;
    assign dma_req_en   = ctl_q.dma_en && !ctl_q.svc;
    assign reg_rdata    = ctl_read(ctl_q, f_full, f_empty);
    assign host_rd_data = f_head;
    assign per_pop_data = f_head;
endmodule

// File: rtl/ecp_svc_chk.sv
// Module: ecp_svc_chk
// Port-level properties of ecp_svc_ctrl, attached with bind.
module ecp_svc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dir,
    input logic       host_rd_en,
    input logic       per_pop,
    input logic       reg_wr_en,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       dma_req_en,
    input logic       irq,
    input logic       flt_low
);
    logic pop_req;
    assign pop_req = dir ? host_rd_en : per_pop;

    // R1: the flags are mutually exclusive.
    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rdata[1] && reg_rdata[0]));

    // R2: without a pop request, full stays full.
    a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1] && !pop_req) |=> reg_rdata[1]);

    // R5: DMA request only when enabled and the latch is clear.
    a_r5_dma_gate: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_en |-> (reg_rdata[3] && !reg_rdata[2]));

    // R9: a set latch is cleared only by software.
    a_r9_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[2] && !reg_wr_en) |=> reg_rdata[2]);

    // R11: enabling error interrupts over a low line fires.
    a_r11_enable_low_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_rdata[4] && !reg_wdata[4] && flt_low) |=> irq);
endmodule

bind ecp_svc_ctrl ecp_svc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dir(dir), .host_rd_en(host_rd_en),
    .per_pop(per_pop), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dma_req_en(dma_req_en), .irq(irq),
    .flt_low(flt_low)
);

// File: tb/ecp_svc_ctrl_bench.sv
// Directed bench for ecp_svc_ctrl; inputs driven and outputs sampled at falling edges.
module ecp_svc_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir = 1'b0;
    logic       host_wr_en = 1'b0, host_rd_en = 1'b0, per_push = 1'b0, per_pop = 1'b0;
    logic [7:0] host_wr_data = '0, per_push_data = '0, reg_wdata = '0;
    logic       reg_wr_en = 1'b0, dma_tc = 1'b0, nfault = 1'b1;
    logic [7:0] host_rd_data, per_pop_data, reg_rdata;
    logic       irq, dma_req_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ecp_svc_ctrl u_ecp_svc_ctrl (
        .clk(clk), .rst_n(rst_n), .dir(dir),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
        .per_push(per_push), .per_push_data(per_push_data),
        .per_pop(per_pop), .per_pop_data(per_pop_data),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dma_tc(dma_tc), .nfault(nfault), .irq(irq), .dma_req_en(dma_req_en)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        reg_wdata = v; reg_wr_en = 1'b1; tick(); reg_wr_en = 1'b0;
    endtask

    task automatic push_host(input logic [7:0] d);
        host_wr_data = d; host_wr_en = 1'b1; tick(); host_wr_en = 1'b0;
    endtask

    task automatic push_per(input logic [7:0] d);
        per_push_data = d; per_push = 1'b1; tick(); per_push = 1'b0;
    endtask

    task automatic pop_per();
        per_pop = 1'b1; tick(); per_pop = 1'b0;
    endtask

    task automatic pop_host();
        host_rd_en = 1'b1; tick(); host_rd_en = 1'b0;
    endtask

    task automatic quiet(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            tick();
            check(tag, {7'd0, irq}, 8'd0);
        end
    endtask

    // R4, R9: reset state and no interrupt while the latch is set.
    task automatic t_reset();
        check("R4 ctl", reg_rdata, 8'h15);
        check("R4 irq", {7'd0, irq}, 8'd0);
        check("R4 dreq", {7'd0, dma_req_en}, 8'd0);
        quiet("R9 latch set quiet", 4);
    endtask

    // R1, R2, R3: fill, overflow, ordered drain.
    task automatic t_full();
        dir = 1'b0;
        push_host(8'd1);
        check("R1 one byte flags", {6'd0, reg_rdata[1:0]}, 8'd0);
        for (int i = 1; i < 16; i++) push_host(8'(i * 3 + 1));
        check("R2 full flags", {6'd0, reg_rdata[1:0]}, 8'd2);
        push_host(8'hFF);
        check("R2 full after drop", {6'd0, reg_rdata[1:0]}, 8'd2);
        for (int i = 0; i < 16; i++) begin
            check("R3 order", per_pop_data, 8'(i * 3 + 1));
            pop_per();
        end
        check("R1 empty flags", {6'd0, reg_rdata[1:0]}, 8'd1);
    endtask

    // R6: write-direction threshold, boundary at 7 and 8 free.
    task automatic t_thr_wr();
        for (int i = 0; i < 9; i++) push_host(8'(8'h40 + i));
        wr_ctl(8'h10);
        check("R6 armed", {7'd0, reg_rdata[2]}, 8'd0);
        quiet("R6 7 free quiet", 3);
        pop_per();
        check("R6 not yet", {7'd0, irq}, 8'd0);
        tick();
        check("R6 pulse", {7'd0, irq}, 8'd1);
        check("R6 latch set", {7'd0, reg_rdata[2]}, 8'd1);
        tick();
        check("R6 pulse ends", {7'd0, irq}, 8'd0);
        for (int i = 0; i < 8; i++) pop_per();
    endtask

    // R7, R3: read-direction threshold and host read routing.
    task automatic t_thr_rd();
        dir = 1'b1;
        for (int i = 0; i < 7; i++) push_per(8'(8'h80 + i));
        wr_ctl(8'h10);
        quiet("R7 7 held quiet", 3);
        push_per(8'h87);
        check("R7 not yet", {7'd0, irq}, 8'd0);
        tick();
        check("R7 pulse", {7'd0, irq}, 8'd1);
        tick();
        check("R7 pulse ends", {7'd0, irq}, 8'd0);
        for (int i = 0; i < 8; i++) begin
            check("R3 host read", host_rd_data, 8'(8'h80 + i));
            pop_host();
        end
        dir = 1'b0;
    endtask

    // R5, R8: DMA enable gating and terminal count.
    task automatic t_dma();
        wr_ctl(8'h1C);
        check("R5 dma bit", {7'd0, reg_rdata[3]}, 8'd1);
        check("R5 gated by latch", {7'd0, dma_req_en}, 8'd0);
        wr_ctl(8'h18);
        check("R5 dreq on", {7'd0, dma_req_en}, 8'd1);
        quiet("R8 threshold ignored", 3);
        dma_tc = 1'b1; tick(); dma_tc = 1'b0;
        check("R8 tc pulse", {7'd0, irq}, 8'd1);
        check("R8 latch set", {7'd0, reg_rdata[2]}, 8'd1);
        check("R5 dreq off", {7'd0, dma_req_en}, 8'd0);
        tick();
        check("R8 pulse ends", {7'd0, irq}, 8'd0);
        wr_ctl(8'h14);
        check("R5 dma cleared", {7'd0, reg_rdata[3]}, 8'd0);
        check("R9 write one quiet", {7'd0, irq}, 8'd0);
    endtask

    // R10: fault edge with interrupt disabled, then enabled.
    task automatic t_fault_edge();
        nfault = 1'b0;
        quiet("R10 disabled quiet", 5);
        nfault = 1'b1;
        quiet("R10 rise quiet", 4);
        wr_ctl(8'h04);
        check("R10 enable high quiet", {7'd0, irq}, 8'd0);
        nfault = 1'b0;
        quiet("R10 sync delay", 2);
        tick();
        check("R10 edge pulse", {7'd0, irq}, 8'd1);
        tick();
        check("R10 pulse ends", {7'd0, irq}, 8'd0);
        nfault = 1'b1;
        quiet("R10 rise enabled quiet", 4);
    endtask

    // R11: enable cleared while the line is low.
    task automatic t_fault_clr();
        wr_ctl(8'h14);
        nfault = 1'b0;
        quiet("R11 low disabled", 4);
        wr_ctl(8'h04);
        check("R11 pulse", {7'd0, irq}, 8'd1);
        tick();
        check("R11 pulse ends", {7'd0, irq}, 8'd0);
        wr_ctl(8'h04);
        check("R11 no refire", {7'd0, irq}, 8'd0);
        nfault = 1'b1;
        quiet("R11 release", 4);
    endtask

    // R12: mode bits are storage only.
    task automatic t_mode();
        wr_ctl(8'hF4);
        check("R12 readback", reg_rdata, 8'hF5);
        quiet("R12 no irq", 2);
        check("R12 no dreq", {7'd0, dma_req_en}, 8'd0);
        wr_ctl(8'h14);
        check("R12 cleared", reg_rdata, 8'h15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_full();
        t_thr_wr();
        t_thr_rd();
        t_dma();
        t_fault_edge();
        t_fault_clr();
        t_mode();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule